// File: doc/BRIEF.md
# Two-Phase LDPC Processing Element Sequencer

This block turns one schedule word per clock into the strobes and addresses that drive a layered LDPC processing element working in two overlapping phases. Each schedule word says whether the first phase is active, whether the current index is the last one of its row, which phase-one index is being worked on, and which gamma-RAM location to read. From this the sequencer produces the gamma-RAM read and write addressing, the indices for both phases, the start strobe for the R-new register, the load strobe for the G-new register, and the control of a single-port R memory that holds one entry per row.

Because the second phase of one row runs while the first phase of the next row starts, the R memory must be written and read in a staggered way. The row just finished is written back on the first index of the following row, and the R value of the next row is read on the last index of the current row. An internal row counter supplies the R memory addresses. It wraps after the final row and flags the start of a new decoding iteration.

The schedule word is a plain per-cycle control input with no handshake. The sequencer never stalls, and every output is registered, so each result appears one clock after its schedule word. A row must span at least two indices: its first and last index may not fall in the same cycle.

Top module: `ldpc_pe_sequencer`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the first clock after it, g_we, rnew_start, gnew_load and iter_start are 0, r_rd_nwr is 1 (read mode) and r_addr is 0.
- R2: g_raddr equals cw_g_raddr of the previous cycle, and p2_idx equals g_raddr of the previous cycle, which is cw_g_raddr from two cycles earlier.
- R3: p1_idx and g_waddr both equal cw_p1_idx of the previous cycle.
- R4: g_we equals cw_p1_act of the previous cycle.
- R5: A schedule word with cw_p1_act=1 and cw_last=1 gives, one cycle later, gnew_load=1, r_rd_nwr=1 and r_addr equal to the next row number.
- R6: The next row number is the current row plus one, and it wraps from NROWS-1 to 0. The current row advances only on a last index.
- R7: The first active index after a finished row gives, one cycle later, r_rd_nwr=0 (write), r_addr equal to the row just finished, rnew_start=1 and gnew_load=0.
- R8: The first active index after reset, when no row has finished yet, gives rnew_start=1 with r_rd_nwr=1 and r_addr equal to the current row (row 0). No write is issued.
- R9: Any other active index gives r_rd_nwr=1, r_addr equal to the current row, gnew_load=0 and rnew_start=0.
- R10: A schedule word with cw_p1_act=0 gives g_we=0, rnew_start=0, gnew_load=0, iter_start=0, r_rd_nwr=1 and r_addr equal to the current row. The row state does not change.
- R11: iter_start is 1 exactly when a last-index output targets next row 0, that is, on the wrap to a new iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cw_p1_act | input | 1 | Schedule word: first phase active |
| cw_last | input | 1 | Schedule word: last index of the row |
| cw_p1_idx | input | IDXW | Schedule word: phase-one index |
| cw_g_raddr | input | GAW | Schedule word: gamma-RAM read address |
| g_raddr | output | GAW | Gamma-RAM read address |
| g_waddr | output | IDXW | Gamma-RAM write address |
| g_we | output | 1 | Gamma-RAM write enable |
| p1_idx | output | IDXW | Phase-one index |
| p2_idx | output | GAW | Phase-two index (read address delayed by the RAM latency) |
| rnew_start | output | 1 | R-new register start/load |
| gnew_load | output | 1 | G-new register load |
| r_rd_nwr | output | 1 | R memory read (1) / write (0) |
| r_addr | output | RAW | R memory address (row number) |
| iter_start | output | 1 | New decoding iteration begins |

## Verification
The bench plays back a two-row schedule through a full wrap and checks the exact cycle of every R memory write and read and of every G-new load. Three corner cases matter most. On the first row after reset, a design that writes anyway would store garbage into row 0. On the wrap, a design that miscounts would read row 2 or skip the iteration flag. On the first index of a new row, a design that used the advanced row counter instead of the held previous row would overwrite the wrong R entry. Idle cycles between rows check that the strobes go quiet without moving the row counter. The address forwarding checks would catch a design that drops the one-cycle delay of the phase-two index.

// File: rtl/ldpc_pe_pkg.sv
package ldpc_pe_pkg;

  typedef struct packed {
    logic g_we;
    logic rnew;
    logic gnew;
    logic rd_nwr;
    logic iter;
  } pe_strobe_t;

  localparam pe_strobe_t STROBE_IDLE = '{g_we: 1'b0, rnew: 1'b0, gnew: 1'b0,
                                         rd_nwr: 1'b1, iter: 1'b0};

endpackage

// File: rtl/ldpc_pe_row_ctr.sv
module ldpc_pe_row_ctr #(
  parameter int NROWS = 46,
  localparam int RAW = (NROWS > 1) ? $clog2(NROWS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  output logic [RAW-1:0] row,
  output logic [RAW-1:0] next_row,
  output logic [RAW-1:0] prev_row
);

  localparam logic [RAW-1:0] LAST_ROW = RAW'(NROWS - 1);

  assign next_row = (row == LAST_ROW) ? '0 : row + RAW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row      <= '0;
      prev_row <= '0;
    end else if (advance) begin
      row      <= next_row;
      prev_row <= row;
    end
  end

  // R6: the row number never leaves the row range
  a_r6_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row) < NROWS);

  // R6: after an advance, the row that was left is held as the previous row
  a_r6_prev_follows: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> prev_row == $past(row));

endmodule

// File: rtl/ldpc_pe_phase_dec.sv
module ldpc_pe_phase_dec #(
  parameter int RAW = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    act,
  input  logic                    last,
  input  logic [RAW-1:0]          row,
  input  logic [RAW-1:0]          next_row,
  input  logic [RAW-1:0]          prev_row,
  output logic                    advance,
  output ldpc_pe_pkg::pe_strobe_t strobe,
  output logic [RAW-1:0]          addr
);
  import ldpc_pe_pkg::*;

  logic first_pend;
  logic prev_done;

  assign advance = act & last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_pend <= 1'b1;
      prev_done  <= 1'b0;
    end else if (act) begin
      if (last) begin
        first_pend <= 1'b1;
        prev_done  <= 1'b1;
      end else begin
        first_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe = STROBE_IDLE;
    addr   = row;
    if (act) begin
      strobe.g_we = 1'b1;
      if (last) begin
        strobe.gnew = 1'b1;
        addr        = next_row;
        strobe.iter = (next_row == '0);
      end else if (first_pend) begin
        strobe.rnew = 1'b1;
        if (prev_done) begin
          strobe.rd_nwr = 1'b0;
          addr          = prev_row;
        end
      end
    end
  end

  // R7: a write strobe is only ever decoded on a first index
  a_r7_write_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.rd_nwr |-> strobe.rnew && !strobe.gnew);

  // R8: no write can be decoded before any row has completed
  a_r8_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_done |-> strobe.rd_nwr);

endmodule

// File: rtl/ldpc_pe_idx_pipe.sv
module ldpc_pe_idx_pipe #(
  parameter int IDXW = 8,
  parameter int GAW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] in_p1_idx,
  input  logic [GAW-1:0]  in_g_raddr,
  output logic [IDXW-1:0] p1_idx,
  output logic [IDXW-1:0] g_waddr,
  output logic [GAW-1:0]  g_raddr,
  output logic [GAW-1:0]  p2_idx
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_idx  <= '0;
      g_waddr <= '0;
      g_raddr <= '0;
      p2_idx  <= '0;
    end else begin
      p1_idx  <= in_p1_idx;
      g_waddr <= in_p1_idx;
      g_raddr <= in_g_raddr;
      p2_idx  <= g_raddr;
    end
  end

  // R2: phase-two index trails the forwarded read address by the RAM latency
  a_r2_p2_lags: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> p2_idx == $past(g_raddr));

  // R3: write address and phase-one index always agree
  a_r3_waddr_matches: assert property (@(posedge clk) disable iff (!rst_n)
    g_waddr == p1_idx);

endmodule

// File: rtl/ldpc_pe_sequencer.sv
module ldpc_pe_sequencer #(
  parameter int NROWS = 46,
  parameter int IDXW  = 8,
  parameter int GAW   = 8,
  localparam int RAW  = (NROWS > 1) ? $clog2(NROWS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cw_p1_act,
  input  logic            cw_last,
  input  logic [IDXW-1:0] cw_p1_idx,
  input  logic [GAW-1:0]  cw_g_raddr,
  output logic [GAW-1:0]  g_raddr,
  output logic [IDXW-1:0] g_waddr,
  output logic            g_we,
  output logic [IDXW-1:0] p1_idx,
  output logic [GAW-1:0]  p2_idx,
  output logic            rnew_start,
  output logic            gnew_load,
  output logic            r_rd_nwr,
  output logic [RAW-1:0]  r_addr,
  output logic            iter_start
);
  import ldpc_pe_pkg::*;

  logic [RAW-1:0] row, next_row, prev_row, dec_addr;
  logic           advance;
  pe_strobe_t     dec_strobe, strobe_q;

  ldpc_pe_row_ctr #(.NROWS(NROWS)) u_row_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .row      (row),
    .next_row (next_row),
    .prev_row (prev_row)
  );

  ldpc_pe_phase_dec #(.RAW(RAW)) u_phase_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (cw_p1_act),
    .last     (cw_last),
    .row      (row),
    .next_row (next_row),
    .prev_row (prev_row),
    .advance  (advance),
    .strobe   (dec_strobe),
    .addr     (dec_addr)
  );

  ldpc_pe_idx_pipe #(.IDXW(IDXW), .GAW(GAW)) u_idx_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_p1_idx  (cw_p1_idx),
    .in_g_raddr (cw_g_raddr),
    .p1_idx     (p1_idx),
    .g_waddr    (g_waddr),
    .g_raddr    (g_raddr),
    .p2_idx     (p2_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= STROBE_IDLE;
      r_addr   <= '0;
    end else begin
      strobe_q <= dec_strobe;
      r_addr   <= dec_addr;
    end
  end

  assign g_we       = strobe_q.g_we;
  assign rnew_start = strobe_q.rnew;
  assign gnew_load  = strobe_q.gnew;
  assign r_rd_nwr   = strobe_q.rd_nwr;
  assign iter_start = strobe_q.iter;

  // R10: an idle schedule word leaves every strobe quiet and the memory in read
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_p1_act |=> !g_we && !rnew_start && !gnew_load && !iter_start && r_rd_nwr);

  // R5: a G-new load always coincides with an R memory read
  a_r5_gnew_reads: assert property (@(posedge clk) disable iff (!rst_n)
    gnew_load |-> r_rd_nwr && !rnew_start);

  // R11: the iteration flag only accompanies a last-index read of row 0
  a_r11_iter_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    iter_start |-> gnew_load && r_addr == '0);

  // R4: write enable trails the first-phase flag by one cycle
  a_r4_we_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(g_we) |-> $past(cw_p1_act));

endmodule

// File: tb/ldpc_pe_sequencer_bench.sv
module ldpc_pe_sequencer_bench;

  localparam int NROWS = 2;
  localparam int IDXW  = 8;
  localparam int GAW   = 6;
  localparam int RAW   = 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cw_p1_act = 1'b0, cw_last = 1'b0;
  logic [IDXW-1:0] cw_p1_idx = '0;
  logic [GAW-1:0]  cw_g_raddr = '0;
  logic [GAW-1:0]  g_raddr, p2_idx;
  logic [IDXW-1:0] g_waddr, p1_idx;
  logic            g_we, rnew_start, gnew_load, r_rd_nwr, iter_start;
  logic [RAW-1:0]  r_addr;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [GAW-1:0] prev_gra = '0;

  always #4 clk = ~clk;

  ldpc_pe_sequencer #(.NROWS(NROWS), .IDXW(IDXW), .GAW(GAW)) u_ldpc_pe_sequencer (
    .clk, .rst_n, .cw_p1_act, .cw_last, .cw_p1_idx, .cw_g_raddr,
    .g_raddr, .g_waddr, .g_we, .p1_idx, .p2_idx, .rnew_start,
    .gnew_load, .r_rd_nwr, .r_addr, .iter_start
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // drive one schedule word at a falling edge, sample its result at the next
  task automatic step(input logic act, input logic last,
                      input logic [IDXW-1:0] p1, input logic [GAW-1:0] gra);
    cw_p1_act = act; cw_last = last; cw_p1_idx = p1; cw_g_raddr = gra;
    @(negedge clk);
    chk("R2 g_raddr", g_raddr, gra);
    chk("R2 p2_idx", p2_idx, prev_gra);
    chk("R3 p1_idx", p1_idx, p1);
    chk("R3 g_waddr", g_waddr, p1);
    chk("R4 g_we", g_we, act);
    prev_gra = gra;
  endtask

  task automatic strobes(input string tag, input bit rn, input bit gn,
                         input bit rd, input int ad, input bit it);
    chk({tag, " rnew_start"}, rnew_start, rn);
    chk({tag, " gnew_load"}, gnew_load, gn);
    chk({tag, " r_rd_nwr"}, r_rd_nwr, rd);
    chk({tag, " r_addr"}, r_addr, ad);
    chk({tag, " iter_start"}, iter_start, it);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 g_we", g_we, 0);
    strobes("R1", 0, 0, 1, 0, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_first_row();
    step(1, 0, 8'd10, 6'd3);  strobes("R8 first row", 1, 0, 1, 0, 0);
    step(1, 0, 8'd11, 6'd4);  strobes("R9 middle", 0, 0, 1, 0, 0);
    step(1, 1, 8'd12, 6'd5);  strobes("R5 last row0", 0, 1, 1, 1, 0);
  endtask

  task automatic t_second_row_wrap();
    step(1, 0, 8'd20, 6'd7);  strobes("R7 write row0", 1, 0, 0, 0, 0);
    step(1, 0, 8'd21, 6'd8);  strobes("R9 middle row1", 0, 0, 1, 1, 0);
    step(1, 1, 8'd22, 6'd9);  strobes("R6 R11 wrap", 0, 1, 1, 0, 1);
  endtask

  task automatic t_idle_gap();
    step(0, 0, 8'd0, 6'd1);   strobes("R10 idle a", 0, 0, 1, 0, 0);
    step(0, 1, 8'd5, 6'd2);   strobes("R10 idle b", 0, 0, 1, 0, 0);
  endtask

  task automatic t_third_row();
    step(1, 0, 8'd30, 6'd11); strobes("R7 write row1", 1, 0, 0, 1, 0);
    step(1, 0, 8'd31, 6'd12); strobes("R9 middle again", 0, 0, 1, 0, 0);
    step(1, 1, 8'd32, 6'd13); strobes("R5 last no wrap", 0, 1, 1, 1, 0);
    step(0, 0, 8'd0, 6'd0);   strobes("R10 trailing idle", 0, 0, 1, 1, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_first_row();
    t_second_row_wrap();
    t_idle_gap();
    t_third_row();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule